// File: doc/BRIEF.md
# Auto-Reload Update Timer

A 16-bit up-counting timer whose main job is deciding when an update event happens, what that event does, and whether it is reported. The counter runs while the enable bit is set. It wraps to zero after matching the active reload value. An update event copies the buffered reload value into the active one, can stop the counter in one-pulse operation, and may set a sticky update flag. Setting the flag also produces a one-cycle DMA request pulse.

Update events have three sources: a counter overflow, a software update-generation strobe, and a pulse from an external slave controller. A source-select bit limits reporting to overflows only. An update-disable bit suppresses events altogether. A clock-division field sets the rate of a sampling-tick enable used by neighbouring filters. The reset input is asserted asynchronously and released synchronously through a two-stage synchroniser.

Register map: address 0 is control, 1 is status, 2 is counter and 3 is reload. Writes take effect at the clock edge. Reads are combinational from `rd_addr`.

Top module: `upd_timer`

## Requirements
- R1: The control register resets to zero. Its fields are: bit 0 enable, bit 1 update disable, bit 2 source select, bit 3 one-pulse, bit 7 reload buffering, bits 9:8 division and bit 11 flag mirroring. Every other bit is dropped on write and reads as 0.
- R2: With bit 7 clear, a reload write (address 3) changes the active compare value at once. With bit 7 set, the value waits in a buffer until the next update event. Address 3 always reads back the buffer.
- R3: While enabled, the counter increments once per clock. When it equals the active reload value it overflows and reads 0 on the next cycle. A write to address 2 loads the counter.
- R4: With one-pulse set, any update event clears the enable bit in the following cycle, and this clear wins over a simultaneous control write.
- R5: With the source select clear, an overflow, a software strobe or a slave pulse each sets the update flag (status bit 0).
- R6: With the source select set, only an overflow sets the flag. Strobes and slave pulses still cause an update (counter cleared, buffer loaded).
- R7: With update disable set, no update event occurs: no buffer load, no flag, no one-pulse stop. The strobes still clear the counter.
- R8: The flag is sticky. Writing status with bit 0 at 0 clears it, writing bit 0 at 1 has no effect, and a set in the same cycle wins over a clear.
- R9: Counter readback bit 31 shows the flag when control bit 11 is set, and 0 otherwise. Bits 30:16 read 0.
- R10: The sampling tick is high every clock for division 00 and for the reserved 11. It is high every second clock for 01 and every fourth clock for 10, with the phase counted from reset release.
- R11: The DMA request is a one-cycle pulse in the cycle the flag becomes set by an event; the interrupt output follows the flag.
- R12: A software strobe clears the counter and performs the buffer load even while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data |
| sw_ug | input | 1 | Software update-generation strobe |
| slv_upd | input | 1 | Slave-controller update pulse |
| upd_irq | output | 1 | Update interrupt request (flag level) |
| upd_dma | output | 1 | Update DMA request pulse |
| smp_tick | output | 1 | Sampling clock enable |

## Verification
A behavioural model in the bench predicts every output and the addressed readback on every clock. It is driven first through directed sequences and then through a long random mix.

The directed sequences cover several distinct cases:
- Free counting with an unbuffered reload, then with a buffered one. This separates immediate from deferred reload.
- Strobes and slave pulses under each source-select value. This separates an event that is reported from one that only updates.
- Update disable combined with a pending buffer.
- One-pulse stop, followed by a strobe while the counter is stopped.
- A zero reload, which overflows every cycle, combined with a status clear. This shows that a set wins over a clear.
- Each division code.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_STAT   = 2'd1,
    ADDR_CNT    = 2'd2,
    ADDR_RELOAD = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_W   = 12;
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_UDIS   = 1;
  localparam int unsigned B_SRC    = 2;
  localparam int unsigned B_ONEP   = 3;
  localparam int unsigned B_BUF    = 7;
  localparam int unsigned B_DIV_LO = 8;
  localparam int unsigned B_MIRROR = 11;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 12'hB8F;

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_2   = 2'b01,
    DIV_4   = 2'b10,
    DIV_RSV = 2'b11
  } div_e;
endpackage

// File: rtl/upd_timer_ctrl.sv
module upd_timer_ctrl
  import upd_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              stop_req,
  output logic [CTRL_W-1:0] ctrl
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) ctrl_d = wdata & CTRL_MASK;
    if (stop_req) ctrl_d[B_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R4: one-pulse stop wins over a control write
  a_r4_onep_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !ctrl_q[B_EN]);
endmodule

// File: rtl/upd_timer_core.sv
module upd_timer_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             udis,
  input  logic             src_ovf_only,
  input  logic             onep,
  input  logic             buf_en,
  input  logic             cnt_wr,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             sw_ug,
  input  logic             slv_upd,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld_buf,
  output logic             flag_set,
  output logic             stop_req
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic ovf, reinit, uev;

  assign ovf    = en && (cnt_q == act_q);
  assign reinit = sw_ug || slv_upd;
  assign uev    = !udis && (ovf || reinit);

  always_comb begin
    cnt_d = cnt_q;
    if (reinit)      cnt_d = '0;
    else if (cnt_wr) cnt_d = wdata;
    else if (en)     cnt_d = ovf ? '0 : cnt_q + ONE;
  end

  always_comb begin
    buf_d = rld_wr ? wdata : buf_q;
    act_d = act_q;
    if (rld_wr && !buf_en) act_d = wdata;
    else if (uev)          act_d = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  assign cnt      = cnt_q;
  assign rld_buf  = buf_q;
  assign flag_set = uev && (ovf || !src_ovf_only);
  assign stop_req = uev && onep;

  // R3: a match with no reinit or write is followed by zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == act_q && !reinit && !cnt_wr) |=> (cnt_q == '0));
  // R7: update disable freezes the active value unless written directly
  a_r7_udis_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (udis && !(rld_wr && !buf_en)) |=> $stable(act_q));
  // R12: a strobe always clears the counter
  a_r12_ug_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ug |=> (cnt_q == '0));
endmodule

// File: rtl/upd_timer_flag.sv
module upd_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic dma
);
  logic flag_q, flag_d, dma_q;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      dma_q  <= set;
    end
  end

  assign flag = flag_q;
  assign dma  = dma_q;

  // R8: only a clear can drop the flag
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R11: a DMA pulse comes only with a set flag
  a_r11_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> flag_q);
endmodule

// File: rtl/upd_timer_div.sv
module upd_timer_div
  import upd_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  assign pre_d = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    unique case (div_e'(div))
      DIV_2:   tick = pre_q[0];
      DIV_4:   tick = &pre_q[1:0];
      default: tick = 1'b1;
    endcase
  end

  // R10: divide-by-four never ticks twice in a row
  a_r10_div4_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (div == 2'b10 && tick) |=> (!tick || div != 2'b10));
endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import upd_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sw_ug,
  input  logic              slv_upd,
  output logic              upd_irq,
  output logic              upd_dma,
  output logic              smp_tick
);
  localparam int unsigned PAD_W = DATA_W - 1 - CNT_W;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic              ctrl_wr, stat_wr, cnt_wr, rld_wr;
  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  cnt, rld_buf;
  logic              flag_set, stop_req, flag;
  logic              unused_wdata;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign stat_wr = wr_en && (wr_addr == ADDR_STAT);
  assign cnt_wr  = wr_en && (wr_addr == ADDR_CNT);
  assign rld_wr  = wr_en && (wr_addr == ADDR_RELOAD);
  assign unused_wdata = ^wr_data[DATA_W-1:CNT_W];

  upd_timer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s2), .wr(ctrl_wr),
    .wdata(wr_data[CTRL_W-1:0]), .stop_req(stop_req), .ctrl(ctrl)
  );

  upd_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_s2),
    .en(ctrl[B_EN]), .udis(ctrl[B_UDIS]), .src_ovf_only(ctrl[B_SRC]),
    .onep(ctrl[B_ONEP]), .buf_en(ctrl[B_BUF]),
    .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wdata(wr_data[CNT_W-1:0]),
    .sw_ug(sw_ug), .slv_upd(slv_upd),
    .cnt(cnt), .rld_buf(rld_buf), .flag_set(flag_set), .stop_req(stop_req)
  );

  upd_timer_flag u_flag (
    .clk(clk), .rst_n(rst_s2), .set(flag_set),
    .clr(stat_wr && !wr_data[0]), .flag(flag), .dma(upd_dma)
  );

  upd_timer_div #(.PRE_W(2)) u_div (
    .clk(clk), .rst_n(rst_s2), .div(ctrl[B_DIV_LO+1:B_DIV_LO]), .tick(smp_tick)
  );

  assign upd_irq = flag;

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      ADDR_CTRL:  rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      ADDR_STAT:  rd_data = {{(DATA_W-1){1'b0}}, flag};
      ADDR_CNT:   rd_data = {ctrl[B_MIRROR] & flag, {PAD_W{1'b0}}, cnt};
      default:    rd_data = {{(DATA_W-CNT_W){1'b0}}, rld_buf};
    endcase
  end

  // R9: mirrored bit is zero whenever mirroring is off
  a_r9_mirror_off: assert property (@(posedge clk) disable iff (!rst_s2)
    (!ctrl[B_MIRROR] && rd_addr == 2'd2) |-> !rd_data[DATA_W-1]);
endmodule

// File: tb/upd_timer_tb_top.sv
module upd_timer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        sw_ug = 1'b0, slv_upd = 1'b0;
  logic        upd_irq, upd_dma, smp_tick;

  always #(CLK_P/2) clk = ~clk;

  upd_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_ug(sw_ug), .slv_upd(slv_upd),
    .upd_irq(upd_irq), .upd_dma(upd_dma), .smp_tick(smp_tick)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  bit        s1 = 0, s2 = 0;
  bit [11:0] m_ctrl;
  bit [15:0] m_cnt, m_buf, m_act;
  bit        m_flag, m_dma;
  int        m_pre;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit in_rst, en, udis, src, onep, bufen, ovf, reinit, uev, fset;
    bit [15:0] wd;
    in_rst = !s2;
    if (!rst_n) begin s1 = 0; s2 = 0; in_rst = 1; end
    else begin s2 = s1; s1 = 1; end
    if (in_rst) begin
      m_ctrl = 0; m_cnt = 0; m_buf = 0; m_act = 0; m_flag = 0; m_dma = 0; m_pre = 0;
    end else begin
      en = m_ctrl[0]; udis = m_ctrl[1]; src = m_ctrl[2]; onep = m_ctrl[3]; bufen = m_ctrl[7];
      wd = wr_data[15:0];
      ovf = en && (m_cnt == m_act);
      reinit = sw_ug || slv_upd;
      uev = !udis && (ovf || reinit);
      fset = uev && (ovf || !src);
      if (reinit) m_cnt = 0;
      else if (wr_en && wr_addr == 2) m_cnt = wd;
      else if (en) m_cnt = ovf ? 16'd0 : 16'(m_cnt + 1);
      if (wr_en && wr_addr == 3 && !bufen) m_act = wd;
      else if (uev) m_act = m_buf;
      if (wr_en && wr_addr == 3) m_buf = wd;
      if (wr_en && wr_addr == 0) m_ctrl = wr_data[11:0] & 12'hB8F;
      if (uev && onep) m_ctrl[0] = 0;
      if (fset) m_flag = 1;
      else if (wr_en && wr_addr == 1 && !wr_data[0]) m_flag = 0;
      m_dma = fset;
      m_pre = (m_pre + 1) % 4;
    end
  end

  always @(posedge clk) begin : compare
    logic [31:0] exp_rd;
    bit exp_tick;
    #(CLK_P/4);
    if (!done) begin
      case (rd_addr)
        2'd0: exp_rd = {20'd0, m_ctrl};
        2'd1: exp_rd = {31'd0, m_flag};
        2'd2: exp_rd = {m_ctrl[11] & m_flag, 15'd0, m_cnt};
        default: exp_rd = {16'd0, m_buf};
      endcase
      case (m_ctrl[9:8])
        2'b01: exp_tick = (m_pre % 2) == 1;
        2'b10: exp_tick = m_pre == 3;
        default: exp_tick = 1;
      endcase
      case (rd_addr)
        2'd0: check("R1/R4 control readback", rd_data, exp_rd);
        2'd1: check("R5/R6/R7/R8 status readback", rd_data, exp_rd);
        2'd2: check("R2/R3/R9/R12 counter readback", rd_data, exp_rd);
        default: check("R2 reload readback", rd_data, exp_rd);
      endcase
      check("R5/R6/R7/R8 upd_irq", {31'd0, upd_irq}, {31'd0, m_flag});
      check("R11 upd_dma", {31'd0, upd_dma}, {31'd0, m_dma});
      check("R10 smp_tick", {31'd0, smp_tick}, {31'd0, exp_tick});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse_ug();
    @(negedge clk); sw_ug = 1; @(negedge clk); sw_ug = 0;
  endtask

  task automatic pulse_slv();
    @(negedge clk); slv_upd = 1; @(negedge clk); slv_upd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    idle(3);
    @(negedge clk) rst_n = 1;
    rd_addr = 0; idle(4);                      // R1 reset value
    wr(0, 32'hFFFF_FFFF); idle(2);             // R1 reserved bits, R10 code 11
    wr(0, 0); idle(1);
    // R3 counting and wrap, unbuffered reload R2
    rd_addr = 2;
    wr(3, 5); wr(0, 1); idle(20);
    // R8 clear, write-one ignored
    rd_addr = 1;
    wr(1, 1); idle(2); wr(1, 0); idle(2);
    // R2 buffered reload: active stays 5 until overflow
    rd_addr = 2;
    wr(0, 32'h81); wr(3, 2); idle(16);
    // R6 source select: strobes update but do not flag
    wr(1, 0); wr(0, 32'h85); wr(3, 9);
    pulse_ug(); idle(3); pulse_slv(); idle(3);
    rd_addr = 1; idle(2);
    // R5 strobes flag with source select clear
    wr(0, 32'h81); wr(1, 0); pulse_slv(); idle(3);
    wr(1, 0); pulse_ug(); idle(3);
    // R7 update disable with pending buffer
    wr(1, 0); wr(0, 32'h83); wr(3, 3); rd_addr = 2; idle(30);
    pulse_ug(); idle(5); rd_addr = 1; idle(2);
    // R4 one-pulse stop
    wr(0, 0); wr(3, 4); wr(2, 0); wr(1, 0);
    rd_addr = 0; wr(0, 32'h09); idle(10); rd_addr = 2; idle(4);
    // R12 strobe while stopped loads buffer
    wr(0, 32'h80); wr(3, 6); pulse_ug(); wr(0, 1); idle(12);
    // R9 mirror
    wr(0, 32'h801); idle(10); wr(1, 0); idle(2);
    // R8 set wins: reload 0 overflows every cycle
    wr(3, 0); wr(0, 1); rd_addr = 1; idle(2);
    wr(1, 0); wr(1, 0); idle(2);
    // R10 division codes
    wr(0, 32'h100); idle(8); wr(0, 32'h200); idle(12); wr(0, 32'h300); idle(4);
    // random mix
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      rd_addr = 2'($urandom);
      wr_en = ($urandom % 6) == 0;
      wr_addr = 2'($urandom);
      wr_data = $urandom;
      if (wr_addr >= 2) wr_data = wr_data & 32'h1F;
      if (wr_addr == 0 && ($urandom % 3) != 0) wr_data[0] = 1;
      sw_ug = ($urandom % 20) == 0;
      slv_upd = ($urandom % 20) == 0;
    end
    @(negedge clk);
    wr_en = 0; sw_ug = 0; slv_upd = 0;
    idle(3);
    finish_run();
  end
endmodule